// File: doc/BRIEF.md
# Tenths-Resolution Stopwatch Counter

This block is the counting core of a four-digit stopwatch. It shows elapsed time as minutes, seconds and tenths of a second (M:SS:D), from 0:00:0 up to 9:59:9. An internal prescaler divides the system clock down to one single-cycle tick per tenth of a second. With the default parameter of 5,000,000 cycles at 50 MHz, that tick comes every 0.1 s.

Each tick advances a chain of four BCD digit counters with radices 10, 10, 6 and 10. In order these are the tenths digit, the seconds units, the seconds tens and the minutes. A carry passes along the chain in the same clock edge as the tick. After 9:59:9 the chain wraps to 0:00:0.

A run input starts and pauses counting. While paused, the prescaler keeps its partial count, so the fraction of a tenth already counted is not lost. A synchronous clear input zeroes the digits and the prescaler, and it takes priority over run. An active-low asynchronous reset does the same. There is no control state machine: the only behaviour is counting, which is gated by the run and clear inputs directly.

Top module: `stopwatch_core`

## Requirements
- R1: After reset (`rst_ni` low) all four digits read 0. The prescaler also restarts, so the first tenth after reset needs a full CLK_PER_TICK cycles of run.
- R2: With `run_i` high and `clear_i` low, `tenths_o` rises by one on the clock edge that ends every CLK_PER_TICK-th running cycle. It does not change on any other edge.
- R3: When a tick finds `tenths_o` at 9, `tenths_o` becomes 0 and `sec_ones_o` advances by one on the same edge.
- R4: A tick at seconds 59 (ones 9, tens 5) with tenths 9 sets both seconds digits to 0 and advances `min_o` by one. A tick at seconds ones 9 and tens below 5 advances `sec_tens_o`.
- R5: A tick at 9:59:9 returns all four digits to 0.
- R6: While `run_i` is low and `clear_i` is low, the digits and the prescaler count hold. After resuming, the next tenth arrives once the remaining cycles of the interrupted tenth have run.
- R7: `clear_i` high zeroes the digits and the prescaler count on the next edge, whatever `run_i` is. This holds even on a cycle where a tick would otherwise have fired.
- R8: The digits always hold valid values (`tenths_o`, `sec_ones_o`, `min_o` at most 9; `sec_tens_o` at most 5). Over 6000 consecutive tenths they step through every time from 0:00:1 to 9:59:9 and back to 0:00:0 in order. Each port is 4-bit binary-coded decimal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | High to count, low to pause |
| clear_i | input | 1 | Synchronous clear, overrides run |
| tenths_o | output | 4 | Tenths-of-a-second digit, BCD 0..9 |
| sec_ones_o | output | 4 | Seconds units digit, BCD 0..9 |
| sec_tens_o | output | 4 | Seconds tens digit, BCD 0..5 |
| min_o | output | 4 | Minutes digit, BCD 0..9 |

## Verification
Two functions can land in the same cycle: the clear, and the prescaler reaching its terminal count with run high. The bench runs exactly CLK_PER_TICK-1 cycles after a clear and then raises clear together with run. A correct block then shows 0:00:0, not 0:00:1. It must also need a full CLK_PER_TICK running cycles before showing 0:00:1, which shows that the partial count was discarded. The full carry from 9:59:9 to 0:00:0 is a second case where every digit changes on one tick. It is checked both by direct landing and by a step-by-step sweep.

// File: rtl/sw_pkg.sv
package sw_pkg;
    localparam int DIGIT_W    = 4;
    localparam int NUM_DIGITS = 4;

    typedef logic [DIGIT_W-1:0] bcd_t;

    // Radix of each position, least significant first:
    // tenths, seconds units, seconds tens, minutes.
    function automatic int radix_of(input int idx);
        case (idx)
            2:       return 6;
            default: return 10;
        endcase
    endfunction
endpackage

// File: rtl/sw_prescaler.sv
module sw_prescaler #(
    parameter int CLK_PER_TICK = 5_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic clear_i,
    output logic tick_o
);
    localparam int CW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
    localparam logic [CW-1:0] TERMINAL = CW'(CLK_PER_TICK - 1);

    logic [CW-1:0] count_q;
    logic          at_end;

    assign at_end = (count_q == TERMINAL);
    assign tick_o = run_i && !clear_i && at_end;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            count_q <= '0;
        end else if (clear_i) begin
            count_q <= '0;
        end else if (run_i) begin
            count_q <= at_end ? '0 : count_q + 1'b1;
        end
    end
endmodule

// File: rtl/sw_digit.sv
module sw_digit
    import sw_pkg::*;
#(
    parameter int RADIX = 10
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic step_i,
    output bcd_t value_o
);
    localparam bcd_t TOP = bcd_t'(RADIX - 1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            value_o <= '0;
        end else if (clear_i) begin
            value_o <= '0;
        end else if (step_i) begin
            value_o <= (value_o == TOP) ? '0 : value_o + 1'b1;
        end
    end
endmodule

// File: rtl/stopwatch_core.sv
module stopwatch_core
    import sw_pkg::*;
#(
    parameter int CLK_PER_TICK = 5_000_000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       run_i,
    input  logic       clear_i,
    output logic [3:0] tenths_o,
    output logic [3:0] sec_ones_o,
    output logic [3:0] sec_tens_o,
    output logic [3:0] min_o
);
    logic                  tick;
    logic [NUM_DIGITS-1:0] step;
    bcd_t                  digit [NUM_DIGITS];

    sw_prescaler #(
        .CLK_PER_TICK(CLK_PER_TICK)
    ) u_prescaler (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run_i),
        .clear_i(clear_i),
        .tick_o (tick)
    );

    assign step[0] = tick;

    // Chain of mixed-radix digits; a position steps when all lower ones roll over.
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        sw_digit #(
            .RADIX(radix_of(g))
        ) u_digit (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .clear_i(clear_i),
            .step_i (step[g]),
            .value_o(digit[g])
        );
        if (g < NUM_DIGITS - 1) begin : g_carry
            assign step[g+1] = step[g] && (digit[g] == bcd_t'(radix_of(g) - 1));
        end
    end

    assign tenths_o   = digit[0];
    assign sec_ones_o = digit[1];
    assign sec_tens_o = digit[2];
    assign min_o      = digit[3];
endmodule

// File: rtl/sw_checker.sv
module sw_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       run_i,
    input logic       clear_i,
    input logic       tick_i,
    input logic [3:0] tenths_i,
    input logic [3:0] sec_ones_i,
    input logic [3:0] sec_tens_i,
    input logic [3:0] min_i
);
    logic at_max;
    assign at_max = (tenths_i == 4'd9) && (sec_ones_i == 4'd9) &&
                    (sec_tens_i == 4'd5) && (min_i == 4'd9);

    p_tenths_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i && tenths_i != 4'd9 |=> tenths_i == $past(tenths_i) + 4'd1);

    p_tenths_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i && !clear_i |=> $stable(tenths_i));

    p_tenths_carry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i && tenths_i == 4'd9 && sec_ones_i != 4'd9
        |=> tenths_i == 4'd0 && sec_ones_i == $past(sec_ones_i) + 4'd1);

    p_minute_carry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i && tenths_i == 4'd9 && sec_ones_i == 4'd9 && sec_tens_i == 4'd5 && min_i != 4'd9
        |=> sec_ones_i == 4'd0 && sec_tens_i == 4'd0 && min_i == $past(min_i) + 4'd1);

    p_full_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i && at_max
        |=> tenths_i == 4'd0 && sec_ones_i == 4'd0 && sec_tens_i == 4'd0 && min_i == 4'd0);

    p_pause_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i && !clear_i
        |=> $stable(tenths_i) && $stable(sec_ones_i) && $stable(sec_tens_i) && $stable(min_i));

    p_clear_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i
        |=> tenths_i == 4'd0 && sec_ones_i == 4'd0 && sec_tens_i == 4'd0 && min_i == 4'd0);

    p_bcd_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tenths_i <= 4'd9 && sec_ones_i <= 4'd9 && sec_tens_i <= 4'd5 && min_i <= 4'd9);
endmodule

bind stopwatch_core sw_checker u_sw_checker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .clear_i   (clear_i),
    .tick_i    (tick),
    .tenths_i  (tenths_o),
    .sec_ones_i(sec_ones_o),
    .sec_tens_i(sec_tens_o),
    .min_i     (min_o)
);

// File: tb/test_stopwatch_core.sv
module test_stopwatch_core;
    localparam int CLK_PERIOD  = 10;
    localparam int TICK_CYCLES = 4;
    localparam int WATCHDOG    = 150_000;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       run_i = 1'b0;
    logic       clear_i = 1'b0;
    logic [3:0] tenths_o, sec_ones_o, sec_tens_o, min_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    stopwatch_core #(
        .CLK_PER_TICK(TICK_CYCLES)
    ) i_stopwatch_core (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run_i),
        .clear_i   (clear_i),
        .tenths_o  (tenths_o),
        .sec_ones_o(sec_ones_o),
        .sec_tens_o(sec_tens_o),
        .min_o     (min_o)
    );

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    always @(posedge clk_i) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            n_checks = n_checks + 1;
            n_fails  = n_fails + 1;
            $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    // Expected display for k tenths elapsed, packed {min, sec tens, sec ones, tenths}.
    function automatic logic [15:0] expect_at(input int k);
        int w;
        w = k % 6000;
        expect_at = {4'((w / 600) % 10), 4'((w / 100) % 6), 4'((w / 10) % 10), 4'(w % 10)};
    endfunction

    function automatic logic [15:0] shown();
        shown = {min_o, sec_tens_o, sec_ones_o, tenths_o};
    endfunction

    task automatic check(input string tag, input logic [15:0] exp);
        logic [15:0] got;
        got = shown();
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic spin(input int n);
        run_i = 1'b1;
        repeat (n) @(negedge clk_i);
    endtask

    task automatic do_clear();
        clear_i = 1'b1;
        run_i   = 1'b0;
        @(negedge clk_i);
        clear_i = 1'b0;
    endtask

    task automatic t_reset_r1();
        check("R1 after power-up reset", expect_at(0));
        spin(2 * TICK_CYCLES + 1);
        check("R1 before mid-run reset", expect_at(2));
        rst_ni = 1'b0;
        #1;
        check("R1 async reset zeroes digits", expect_at(0));
        @(negedge clk_i);
        rst_ni = 1'b1;
        spin(TICK_CYCLES - 1);
        check("R1 partial tenth dropped by reset", expect_at(0));
        spin(1);
        check("R1 first tenth after reset", expect_at(1));
        run_i = 1'b0;
    endtask

    task automatic t_tenths_r2();
        do_clear();
        spin(TICK_CYCLES - 1);
        check("R2 no step before terminal count", expect_at(0));
        spin(1);
        check("R2 first step", expect_at(1));
        spin(2 * TICK_CYCLES);
        check("R2 steady rate", expect_at(3));
        run_i = 1'b0;
    endtask

    task automatic t_carry_r3();
        do_clear();
        spin(9 * TICK_CYCLES);
        check("R3 tenths at nine", expect_at(9));
        spin(TICK_CYCLES);
        check("R3 tenths carry into seconds", expect_at(10));
        run_i = 1'b0;
    endtask

    task automatic t_seconds_r4();
        do_clear();
        spin(99 * TICK_CYCLES);
        check("R4 at 0:09:9", expect_at(99));
        spin(TICK_CYCLES);
        check("R4 seconds units carry into tens", expect_at(100));
        spin(499 * TICK_CYCLES);
        check("R4 at 0:59:9", expect_at(599));
        spin(TICK_CYCLES);
        check("R4 seconds carry into minutes", expect_at(600));
        run_i = 1'b0;
    endtask

    task automatic t_wrap_r5();
        do_clear();
        spin(5999 * TICK_CYCLES);
        check("R5 at 9:59:9", 16'h9599);
        spin(TICK_CYCLES);
        check("R5 wrap to 0:00:0", 16'h0000);
        run_i = 1'b0;
    endtask

    task automatic t_pause_r6();
        do_clear();
        spin(2 * TICK_CYCLES + 2);
        run_i = 1'b0;
        repeat (50) @(negedge clk_i);
        check("R6 digits hold while paused", expect_at(2));
        spin(TICK_CYCLES - 3);
        check("R6 no early step after resume", expect_at(2));
        spin(1);
        check("R6 partial tenth kept", expect_at(3));
        run_i = 1'b0;
    endtask

    task automatic t_clear_r7();
        do_clear();
        spin(TICK_CYCLES - 1);
        clear_i = 1'b1;
        run_i   = 1'b1;
        @(negedge clk_i);
        clear_i = 1'b0;
        check("R7 clear beats coincident tick", expect_at(0));
        spin(TICK_CYCLES - 1);
        check("R7 prescaler restarted by clear", expect_at(0));
        spin(1);
        check("R7 first tenth after clear", expect_at(1));
        spin(3 * TICK_CYCLES + 2);
        run_i = 1'b0;
        clear_i = 1'b1;
        @(negedge clk_i);
        clear_i = 1'b0;
        check("R7 clear while paused", expect_at(0));
        run_i = 1'b0;
    endtask

    task automatic t_sweep_r8();
        int bad;
        bad = 0;
        do_clear();
        for (int k = 1; k <= 6000; k++) begin
            spin(TICK_CYCLES);
            if (shown() !== expect_at(k)) begin
                if (bad == 0) check("R8 sweep sequence", expect_at(k));
                bad++;
            end
        end
        run_i = 1'b0;
        if (bad == 0) check("R8 sweep ends at 0:00:0", 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset_r1();
        t_tenths_r2();
        t_carry_r3();
        t_seconds_r4();
        t_wrap_r5();
        t_pause_r6();
        t_clear_r7();
        t_sweep_r8();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule